// File: doc/BRIEF.md
# Two-Channel Bus-Master Disk Controller Register Bank

This block holds the byte-wide control registers of a two-channel bus-master disk controller and produces the single interrupt line that the two channels share. Software reaches each channel through a four-byte window. Channel 0's window starts at offset 0 and channel 1's at offset 8. Address bit 3 picks the channel and address bits 1:0 pick the register. A window with address bit 2 set is a hole. Within a window, offset 0 is the command byte, offset 2 the status byte and offset 3 the timing byte; these three are stored separately for each channel. Offset 1 is a mode register that both channels share.

The mode register combines a pending flag and a block flag for each channel. The pending flags follow the request levels that come from the drive side. The block flags are written by software. The interrupt output is high while some channel is pending and not blocked. Each channel's status byte mixes three kinds of field: a live activity flag from the DMA engine, sticky error and interrupt flags that the engine sets and software clears by writing ones, and two plain storage bits. A write to a command byte also sends a one-cycle pulse to that channel's DMA engine. Only single-byte accesses take effect.

The block is a register file with no sequencing of its own. Every register changes only on the clock edge after its write or input event. Reads are combinational from the current register contents.

Top module: `bmide_regs`

## Requirements
- R1: After a synchronous reset, every command, status-storage, timing, mask and pending bit reads zero, and `irq` and `cmd_pulse` are low.
- R2: An access takes effect only when `bus_size` is 1. A wider read returns 0xFF in each of the lowest `bus_size` bytes of `bus_rdata` and zero above them. A wider write changes no register.
- R3: A byte write to offset 0 of a channel stores the command byte, which then reads back at that offset. In the cycle after the write edge, `cmd_pulse` for that channel is high for exactly one cycle, and the other channel's pulse stays low.
- R4: A byte write to offset 1 from either window changes only mode bits 4 (channel 0 block) and 5 (channel 1 block). Bits 2 and 3 (the pending flags) and all other bits cannot be written. Both windows read the same mode byte.
- R5: Mode bit 2+c reflects `ch_req[c]` as it was sampled at the previous clock edge.
- R6: `irq` = (mode bit 2 and not mode bit 4) or (mode bit 3 and not mode bit 5).
- R7: In status (offset 2), bits 5 and 6 store the written value. Bit 0 reads `dma_active` of that channel live and writes do not affect it. Bits 3, 4 and 7 read zero.
- R8: Status bit 1 is set by a `dma_err_set` pulse and bit 2 by a `dma_int_set` pulse. Writing a 1 to either bit clears it, and writing a 0 leaves it unchanged. If a set pulse and a clearing write fall in the same cycle, the set pulse wins.
- R9: Offset 3 is a separate read/write timing byte for each channel.
- R10: Byte accesses to offsets 4 to 7 of either half read zero and change nothing, including `cmd_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Byte offset; bit 3 selects the channel |
| bus_size | input | 3 | Access width in bytes |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 32 | Read data, combinational |
| ch_req | input | 2 | Interrupt request level per channel from the drive side |
| dma_active | input | 2 | Activity flag per channel from the DMA engine |
| dma_err_set | input | 2 | Error-flag set pulse per channel |
| dma_int_set | input | 2 | Interrupt-flag set pulse per channel |
| cmd_pulse | output | 2 | One-cycle strobe per channel after a command write |
| irq | output | 1 | Shared level interrupt |

## Verification
The hardest case to reach from the ports is the same-cycle collision between a set pulse from the DMA engine and a software write that clears the same status flag. To reach it, the bench raises `dma_err_set` and drives the clearing write in the same cycle, then reads the status byte back. The status bench walks all 256 write values with both flags set beforehand, which covers every mix of clearing, keeping and storing bits. The interrupt bench crosses all four block-flag settings with all four request patterns, writing through both windows.

// File: rtl/bmide_pkg.sv
package bmide_pkg;
    localparam int N_CH          = 2;
    localparam int BYTE_W        = 8;
    localparam int MODE_PEND_LSB = 2;
    localparam int MODE_MASK_LSB = 4;
    localparam int ST_ACT        = 0;
    localparam int ST_ERR        = 1;
    localparam int ST_INT        = 2;
    localparam logic [BYTE_W-1:0] ST_RW_MASK = 8'h60;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_MODE = 2'd1,
        REG_STAT = 2'd2,
        REG_TIME = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/bmide_mode.sv
module bmide_mode
    import bmide_pkg::*;
#(
    parameter int NCH = N_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    req,
    input  logic              wr_en,
    input  logic [NCH-1:0]    wr_mask,
    output logic [BYTE_W-1:0] mode_q,
    output logic              irq
);
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= req;
            if (wr_en) begin
                mask_q <= wr_mask;
            end
        end
    end

    always_comb begin
        mode_q = '0;
        mode_q[MODE_PEND_LSB +: NCH] = pend_q;
        mode_q[MODE_MASK_LSB +: NCH] = mask_q;
    end

    assign irq = |(pend_q & ~mask_q);

    AST_PEND_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_q == $past(req)));                         // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_q));                              // R4
endmodule

// File: rtl/bmide_chan.sv
module bmide_chan
    import bmide_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              dma_active,
    input  logic              err_set,
    input  logic              int_set,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] stat_rd,
    output logic [BYTE_W-1:0] time_q,
    output logic              cmd_pulse
);
    logic [BYTE_W-1:0] rw_q;
    logic              err_q;
    logic              int_q;
    logic              wr_cmd, wr_stat, wr_time;

    assign wr_cmd  = wr_en && (sel == REG_CMD);
    assign wr_stat = wr_en && (sel == REG_STAT);
    assign wr_time = wr_en && (sel == REG_TIME);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            time_q    <= '0;
            rw_q      <= '0;
            err_q     <= 1'b0;
            int_q     <= 1'b0;
            cmd_pulse <= 1'b0;
        end else begin
            cmd_pulse <= wr_cmd;
            if (wr_cmd)  cmd_q  <= wdata;
            if (wr_time) time_q <= wdata;
            if (wr_stat) rw_q   <= wdata & ST_RW_MASK;
            err_q <= err_set || (err_q && !(wr_stat && wdata[ST_ERR]));
            int_q <= int_set || (int_q && !(wr_stat && wdata[ST_INT]));
        end
    end

    always_comb begin
        stat_rd = rw_q;
        stat_rd[ST_ACT] = dma_active;
        stat_rd[ST_ERR] = err_q;
        stat_rd[ST_INT] = int_q;
    end

    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> cmd_pulse);                                    // R3
    AST_CMD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_cmd |=> !cmd_pulse);                                  // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(wr_stat && wdata[ST_ERR])) |=> err_q);        // R8
    AST_RW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> $stable(rw_q));                              // R7
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_time |=> $stable(time_q));                            // R9
endmodule

// File: rtl/bmide_regs.sv
module bmide_regs
    import bmide_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SIZE_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   ch_req,
    input  logic [N_CH-1:0]   dma_active,
    input  logic [N_CH-1:0]   dma_err_set,
    input  logic [N_CH-1:0]   dma_int_set,
    output logic [N_CH-1:0]   cmd_pulse,
    output logic              irq
);
    localparam int N_BYTES = DATA_W / BYTE_W;
    localparam int CH_BIT  = 3;
    localparam int HOLE_BIT = 2;

    logic     byte_ok, win_hit, wr_byte;
    logic     ch_idx;
    reg_sel_e sel;

    logic [BYTE_W-1:0] cmd_q  [N_CH];
    logic [BYTE_W-1:0] stat_q [N_CH];
    logic [BYTE_W-1:0] time_q [N_CH];
    logic [BYTE_W-1:0] mode_q;

    assign byte_ok = (bus_size == SIZE_W'(1));
    assign win_hit = !bus_addr[HOLE_BIT];
    assign wr_byte = bus_wr && byte_ok && win_hit;
    assign ch_idx  = bus_addr[CH_BIT];
    assign sel     = reg_sel_e'(bus_addr[1:0]);

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        bmide_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_byte && (ch_idx == 1'(c))),
            .sel        (sel),
            .wdata      (bus_wdata),
            .dma_active (dma_active[c]),
            .err_set    (dma_err_set[c]),
            .int_set    (dma_int_set[c]),
            .cmd_q      (cmd_q[c]),
            .stat_rd    (stat_q[c]),
            .time_q     (time_q[c]),
            .cmd_pulse  (cmd_pulse[c])
        );
    end

    bmide_mode #(.NCH(N_CH)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .req     (ch_req),
        .wr_en   (wr_byte && (sel == REG_MODE)),
        .wr_mask (bus_wdata[MODE_MASK_LSB +: N_CH]),
        .mode_q  (mode_q),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (!byte_ok) begin
                for (int i = 0; i < N_BYTES; i++) begin
                    if (i < int'(bus_size)) bus_rdata[i*BYTE_W +: BYTE_W] = '1;
                end
            end else if (win_hit) begin
                unique case (sel)
                    REG_CMD:  bus_rdata[BYTE_W-1:0] = cmd_q[ch_idx];
                    REG_MODE: bus_rdata[BYTE_W-1:0] = mode_q;
                    REG_STAT: bus_rdata[BYTE_W-1:0] = stat_q[ch_idx];
                    REG_TIME: bus_rdata[BYTE_W-1:0] = time_q[ch_idx];
                endcase
            end
        end
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(ch_req) == '0) |-> !irq);                          // R6
    AST_WIDE_RD: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_size == SIZE_W'(N_BYTES)) |-> (bus_rdata == '1)); // R2
    AST_HOLE_RD: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && byte_ok && bus_addr[HOLE_BIT]) |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/bmide_regs_test.sv
module bmide_regs_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [2:0]  bus_size = 3'd1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ch_req = '0;
    logic [1:0]  dma_active = '0;
    logic [1:0]  dma_err_set = '0;
    logic [1:0]  dma_int_set = '0;
    logic [1:0]  cmd_pulse;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmide_regs uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ch_req(ch_req), .dma_active(dma_active),
        .dma_err_set(dma_err_set), .dma_int_set(dma_int_set),
        .cmd_pulse(cmd_pulse), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [2:0] sz, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_size = 3'd1;
    endtask

    task automatic do_read(input logic [3:0] a, input logic [2:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0; bus_size = 3'd1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  exp8;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state of every register
        for (int a = 0; a < 16; a++) begin
            do_read(4'(a), 3'd1, rd);
            check("R1 reset read", rd, 32'h0);
        end
        check("R1 irq low", {31'b0, irq}, 32'h0);
        check("R1 pulse low", {30'b0, cmd_pulse}, 32'h0);

        // R3: command write, pulse timing, read back
        do_write(4'h0, 3'd1, 8'hA5);
        check("R3 pulse ch0", {30'b0, cmd_pulse}, 32'h1);
        @(posedge clk); #1;
        check("R3 pulse ends", {30'b0, cmd_pulse}, 32'h0);
        do_write(4'h8, 3'd1, 8'h3C);
        check("R3 pulse ch1", {30'b0, cmd_pulse}, 32'h2);
        @(posedge clk); #1;
        check("R3 pulse ends ch1", {30'b0, cmd_pulse}, 32'h0);
        do_read(4'h0, 3'd1, rd); check("R3 cmd ch0", rd, 32'hA5);
        do_read(4'h8, 3'd1, rd); check("R3 cmd ch1", rd, 32'h3C);

        // R4 R5 R6: sweep block flags and requests through both windows
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 4; r++) begin
                do_write((m[0] ? 4'h9 : 4'h1), 3'd1, 8'(8'hCF | (m << 4)));
                @(negedge clk) ch_req = 2'(r);
                @(posedge clk); #1;
                exp8 = 8'((r << 2) | (m << 4));
                do_read(4'h1, 3'd1, rd); check("R4 R5 mode ch0 window", rd, {24'b0, exp8});
                do_read(4'h9, 3'd1, rd); check("R4 mode ch1 window", rd, {24'b0, exp8});
                check("R6 irq", {31'b0, irq},
                      {31'b0, ((r & 1) != 0 && (m & 1) == 0) || ((r & 2) != 0 && (m & 2) == 0)});
            end
        end
        @(negedge clk) ch_req = 2'b00;

        // R7 R8: all write values against preset sticky flags
        for (int v = 0; v < 256; v++) begin
            int c;
            logic [3:0] a;
            logic act;
            c = v % 2;
            a = (c != 0) ? 4'hA : 4'h2;
            act = ((v >> 3) & 1) != 0;
            @(negedge clk);
            dma_active[c] = act;
            dma_err_set[c] = 1'b1; dma_int_set[c] = 1'b1;
            @(posedge clk); #1;
            dma_err_set = '0; dma_int_set = '0;
            do_write(a, 3'd1, 8'(v));
            exp8 = 8'((v & 8'h60) | (~v & 8'h06) | (act ? 1 : 0));
            do_read(a, 3'd1, rd);
            check("R7 R8 status sweep", rd, {24'b0, exp8});
        end

        // R8: set pulse and clearing write in the same cycle
        do_write(4'h2, 3'd1, 8'h06);
        @(negedge clk);
        bus_addr = 4'h2; bus_size = 3'd1; bus_wdata = 8'h06; bus_wr = 1'b1;
        dma_err_set[0] = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; dma_err_set = '0;
        do_read(4'h2, 3'd1, rd);
        check("R8 set wins over clear", rd & 32'h06, 32'h02);

        // R9: independent timing bytes
        do_write(4'h3, 3'd1, 8'h11);
        do_write(4'hB, 3'd1, 8'hEE);
        do_read(4'h3, 3'd1, rd); check("R9 timing ch0", rd, 32'h11);
        do_read(4'hB, 3'd1, rd); check("R9 timing ch1", rd, 32'hEE);

        // R2: wide accesses
        do_write(4'h3, 3'd2, 8'h77);
        do_write(4'h0, 3'd4, 8'h55);
        check("R2 wide write no pulse", {30'b0, cmd_pulse}, 32'h0);
        do_read(4'h3, 3'd1, rd); check("R2 wide write ignored", rd, 32'h11);
        do_read(4'h0, 3'd1, rd); check("R2 wide cmd write ignored", rd, 32'hA5);
        do_read(4'h3, 3'd2, rd); check("R2 read size 2", rd, 32'h0000FFFF);
        do_read(4'h0, 3'd4, rd); check("R2 read size 4", rd, 32'hFFFFFFFF);

        // R10: hole offsets
        for (int a = 4; a < 8; a++) begin
            do_write(4'(a), 3'd1, 8'hFF);
            check("R10 hole no pulse", {30'b0, cmd_pulse}, 32'h0);
            do_write(4'(a + 8), 3'd1, 8'hFF);
            do_read(4'(a), 3'd1, rd); check("R10 hole read ch0", rd, 32'h0);
            do_read(4'(a + 8), 3'd1, rd); check("R10 hole read ch1", rd, 32'h0);
        end
        do_read(4'h0, 3'd1, rd); check("R10 cmd untouched", rd, 32'hA5);
        do_read(4'hB, 3'd1, rd); check("R10 timing untouched", rd, 32'hEE);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule